// File: doc/BRIEF.md
# Timestamp-Indexed Triggered Hit Buffer

This block holds front-end hit words until a fixed-latency trigger decision arrives. Every hit carries a 6-bit beam-crossing timestamp in its low bits. The timestamp picks one of 64 small buckets, and the hit is stored there. Arrival order across crossings does not matter. A beam-clock strobe advances an internal crossing counter. Each strobe also empties the bucket the counter moves onto, so a bucket is reused once every 64 beam clocks.

When a Level-1 accept pulse arrives, the block works out which crossing lies a fixed number of beam clocks in the past. The crossing number and a running trigger number go into a small trigger queue. A packetizer takes queue entries one at a time. It copies the whole selected bucket into its own output buffer, then emits a framed packet of 20-bit words: a header, one word per hit in arrival order, and a trailer that carries the hit count and is marked with `out_last`. Two sticky flags are provided. One reports hits lost to a full bucket. The other reports triggers lost to a full queue.

Top module: `hbuf_l1_buffer`

## Requirements
- R1: After reset, `out_valid`, `overflow` and `busy` are 0, the crossing counter is 0, and every bucket is empty.
- R2: Each cycle with `bco_tick` high advances the crossing counter by one, modulo 64. A hit with `hit_valid` high is stored in the bucket given by `hit_word[5:0]`.
- R3: On a `bco_tick`, the bucket that the counter moves onto is emptied. Its hits from 64 beam clocks earlier do not appear in later packets.
- R4: An `l1_accept` pulse selects bucket (counter − LATENCY) mod 64, taking the counter value in the cycle of the pulse. LATENCY defaults to 42.
- R5: A packet starts with the header `{4'hA, trig_num[9:0], bucket[5:0]}`. `trig_num` is 0 for the first accepted trigger after reset and rises by one for each accepted trigger. The header is the first valid word after `out_valid` rises.
- R6: The header is followed, one per cycle with no gaps, by the stored hit words of the bucket, unchanged and in arrival order.
- R7: The packet ends with the trailer `{4'hF, hit_count[15:0]}`. `out_last` is high on the trailer and on no other word.
- R8: A trigger on an empty bucket gives a two-word packet: the header, then a trailer with a count of 0.
- R9: A bucket holds at most 16 hits. Any further hit to a full bucket is dropped, and `overflow` is set and stays set until reset.
- R10: Up to 4 triggers wait in a queue and are served in arrival order. A trigger that arrives while the queue holds 4 entries is dropped, even in a cycle when an entry is being removed. A dropped trigger does not advance `trig_num`, and it sets `busy`, which stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hit_valid | input | 1 | Hit word present this cycle |
| hit_word | input | 20 | Hit word; bits [5:0] are the crossing timestamp |
| bco_tick | input | 1 | Beam-clock strobe, one cycle per crossing |
| l1_accept | input | 1 | Level-1 accept pulse |
| out_valid | output | 1 | Output word valid |
| out_word | output | 20 | Packet word (header, hit or trailer) |
| out_last | output | 1 | Marks the trailer word |
| overflow | output | 1 | Sticky: a hit was dropped because its bucket was full |
| busy | output | 1 | Sticky: a trigger was dropped because the queue was full |

## Verification
The assertions assume that `bco_tick`, `hit_valid` and `l1_accept` are single-cycle pulses relative to the clock. They also assume that a hit's timestamp names a crossing that has been opened but not yet reused. The stimulus meets both assumptions by driving every pulse for exactly one cycle. It writes hits only with the current counter value as their timestamp, and it never changes a bucket between a trigger and the end of that trigger's packet. The only exception is the queue test, where the triggers deliberately arrive back to back while a packet is still being sent.

// File: rtl/hbuf_pkg.sv
package hbuf_pkg;
    localparam int WORD_W   = 20;
    localparam int TS_W     = 6;
    localparam int NBUCK    = 1 << TS_W;
    localparam int TNUM_W   = 10;
    localparam logic [3:0] HDR_TAG = 4'hA;
    localparam logic [3:0] TRL_TAG = 4'hF;

    typedef enum logic [1:0] {PK_IDLE, PK_HDR, PK_DATA, PK_TRL} pk_state_e;

    typedef struct packed {
        logic [TNUM_W-1:0] tnum;
        logic [TS_W-1:0]   bucket;
    } trig_rec_t;

    function automatic logic [WORD_W-1:0] mk_header(trig_rec_t r);
        return {HDR_TAG, r.tnum, r.bucket};
    endfunction

    function automatic logic [WORD_W-1:0] mk_trailer(logic [15:0] n);
        return {TRL_TAG, n};
    endfunction
endpackage

// File: rtl/hbuf_bucket_store.sv
module hbuf_bucket_store
    import hbuf_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          wr_en,
    input  logic [TS_W-1:0]               wr_bucket,
    input  logic [WORD_W-1:0]             wr_word,
    input  logic                          clr_en,
    input  logic [TS_W-1:0]               clr_bucket,
    input  logic [TS_W-1:0]               rd_bucket,
    output logic [DEPTH-1:0][WORD_W-1:0]  rd_row,
    output logic [CNT_W-1:0]              rd_count,
    output logic                          ovf_flag
);
    localparam int SLOT_W = $clog2(DEPTH);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

    logic [DEPTH-1:0][WORD_W-1:0] mem [NBUCK];
    logic [CNT_W-1:0]             cnt [NBUCK];
    logic [CNT_W-1:0]             base;
    logic                         wr_ok;

    // a clear in the same cycle makes the write land in slot 0
    assign base  = (clr_en && clr_bucket == wr_bucket) ? '0 : cnt[wr_bucket];
    assign wr_ok = wr_en && (base < FULL_CNT);

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int b = 0; b < NBUCK; b++) cnt[b] <= '0;
            ovf_flag <= 1'b0;
        end else begin
            if (clr_en) cnt[clr_bucket] <= '0;
            if (wr_ok) cnt[wr_bucket] <= base + 1'b1;
            if (wr_en && !wr_ok) ovf_flag <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_ok) mem[wr_bucket][base[SLOT_W-1:0]] <= wr_word;
    end

    assign rd_row   = mem[rd_bucket];
    assign rd_count = cnt[rd_bucket];
endmodule

// File: rtl/hbuf_trig_queue.sv
module hbuf_trig_queue
    import hbuf_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      push,
    input  trig_rec_t din,
    input  logic      pop,
    output trig_rec_t dout,
    output logic      empty,
    output logic      full,
    output logic      push_ok
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

    trig_rec_t        slots [DEPTH];
    logic [PTR_W-1:0] wp, rp;
    logic [CNT_W-1:0] cnt;
    logic             pop_ok;

    assign empty   = (cnt == '0);
    assign full    = (cnt == FULL_CNT);
    assign push_ok = push && !full;
    assign pop_ok  = pop && !empty;
    assign dout    = slots[rp];

    always_ff @(posedge clk) begin
        if (rst) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (push_ok) wp <= (wp == PTR_W'(DEPTH - 1)) ? '0 : wp + 1'b1;
            if (pop_ok)  rp <= (rp == PTR_W'(DEPTH - 1)) ? '0 : rp + 1'b1;
            cnt <= cnt + CNT_W'(push_ok) - CNT_W'(pop_ok);
        end
    end

    always_ff @(posedge clk) begin
        if (push_ok) slots[wp] <= din;
    end
endmodule

// File: rtl/hbuf_packetizer.sv
module hbuf_packetizer
    import hbuf_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          q_empty,
    input  trig_rec_t                     q_rec,
    output logic                          q_pop,
    input  logic [DEPTH-1:0][WORD_W-1:0]  row,
    input  logic [CNT_W-1:0]              row_count,
    output logic                          out_valid,
    output logic [WORD_W-1:0]             out_word,
    output logic                          out_last
);
    localparam int SLOT_W = $clog2(DEPTH);

    pk_state_e                    st;
    logic [DEPTH-1:0][WORD_W-1:0] obuf;
    logic [CNT_W-1:0]             n_q;
    logic [SLOT_W-1:0]            idx;
    trig_rec_t                    rec_q;

    assign q_pop = (st == PK_IDLE) && !q_empty;

    always_ff @(posedge clk) begin
        if (rst) begin
            st    <= PK_IDLE;
            n_q   <= '0;
            idx   <= '0;
            rec_q <= '0;
        end else begin
            case (st)
                PK_IDLE: if (!q_empty) begin
                    n_q   <= row_count;
                    rec_q <= q_rec;
                    st    <= PK_HDR;
                end
                PK_HDR: begin
                    idx <= '0;
                    st  <= (n_q == '0) ? PK_TRL : PK_DATA;
                end
                PK_DATA: begin
                    idx <= idx + 1'b1;
                    if (CNT_W'(idx) == n_q - 1'b1) st <= PK_TRL;
                end
                default: st <= PK_IDLE;
            endcase
        end
    end

    // whole bucket copied in one cycle when the packet starts
    always_ff @(posedge clk) begin
        if (q_pop) obuf <= row;
    end

    always_comb begin
        out_valid = (st != PK_IDLE);
        out_last  = (st == PK_TRL);
        case (st)
            PK_HDR:  out_word = mk_header(rec_q);
            PK_DATA: out_word = obuf[idx];
            PK_TRL:  out_word = mk_trailer(16'(n_q));
            default: out_word = '0;
        endcase
    end
endmodule

// File: rtl/hbuf_l1_buffer.sv
module hbuf_l1_buffer
    import hbuf_pkg::*;
#(
    parameter int DEPTH    = 16,
    parameter int LATENCY  = 42,
    parameter int TQ_DEPTH = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              hit_valid,
    input  logic [19:0]       hit_word,
    input  logic              bco_tick,
    input  logic              l1_accept,
    output logic              out_valid,
    output logic [19:0]       out_word,
    output logic              out_last,
    output logic              overflow,
    output logic              busy
);
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [TS_W-1:0] LAT_OFF = TS_W'(LATENCY % NBUCK);

    logic [TS_W-1:0]              cur_bco, next_bco;
    logic [TNUM_W-1:0]            tnum;
    trig_rec_t                    new_rec, head_rec;
    logic                         q_empty, q_full, q_push_ok, q_pop;
    logic [DEPTH-1:0][WORD_W-1:0] row;
    logic [CNT_W-1:0]             row_count;

    assign next_bco       = cur_bco + 1'b1;
    assign new_rec.tnum   = tnum;
    assign new_rec.bucket = cur_bco - LAT_OFF;

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_bco <= '0;
            tnum    <= '0;
            busy    <= 1'b0;
        end else begin
            if (bco_tick) cur_bco <= next_bco;
            if (q_push_ok) tnum <= tnum + 1'b1;
            if (l1_accept && q_full) busy <= 1'b1;
        end
    end

    hbuf_bucket_store #(.DEPTH(DEPTH)) u_store (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (hit_valid),
        .wr_bucket  (hit_word[TS_W-1:0]),
        .wr_word    (hit_word),
        .clr_en     (bco_tick),
        .clr_bucket (next_bco),
        .rd_bucket  (head_rec.bucket),
        .rd_row     (row),
        .rd_count   (row_count),
        .ovf_flag   (overflow)
    );

    hbuf_trig_queue #(.DEPTH(TQ_DEPTH)) u_tq (
        .clk     (clk),
        .rst     (rst),
        .push    (l1_accept),
        .din     (new_rec),
        .pop     (q_pop),
        .dout    (head_rec),
        .empty   (q_empty),
        .full    (q_full),
        .push_ok (q_push_ok)
    );

    hbuf_packetizer #(.DEPTH(DEPTH)) u_pk (
        .clk       (clk),
        .rst       (rst),
        .q_empty   (q_empty),
        .q_rec     (head_rec),
        .q_pop     (q_pop),
        .row       (row),
        .row_count (row_count),
        .out_valid (out_valid),
        .out_word  (out_word),
        .out_last  (out_last)
    );
endmodule

// File: rtl/hbuf_l1_buffer_chk.sv
module hbuf_l1_buffer_chk (
    input logic        clk,
    input logic        rst,
    input logic        bco_tick,
    input logic [5:0]  cur_bco,
    input logic        out_valid,
    input logic [19:0] out_word,
    input logic        out_last,
    input logic        overflow,
    input logic        busy
);
    AST_BCO_STEP: assert property (@(posedge clk) disable iff (rst)
        bco_tick |=> cur_bco == $past(cur_bco) + 6'd1); // R2
    AST_HDR_FIRST: assert property (@(posedge clk) disable iff (rst)
        $rose(out_valid) |-> out_word[19:16] == 4'hA); // R5
    AST_TRL_MARK: assert property (@(posedge clk) disable iff (rst)
        out_last |-> (out_valid && out_word[19:16] == 4'hF)); // R7
    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (rst)
        overflow |=> overflow); // R9
    AST_BUSY_STICKY: assert property (@(posedge clk) disable iff (rst)
        busy |=> busy); // R10
endmodule

bind hbuf_l1_buffer hbuf_l1_buffer_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .bco_tick  (bco_tick),
    .cur_bco   (cur_bco),
    .out_valid (out_valid),
    .out_word  (out_word),
    .out_last  (out_last),
    .overflow  (overflow),
    .busy      (busy)
);

// File: tb/test_hbuf_l1_buffer.sv
module test_hbuf_l1_buffer;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        hit_valid = 1'b0;
    logic [19:0] hit_word = '0;
    logic        bco_tick = 1'b0;
    logic        l1_accept = 1'b0;
    logic        out_valid, out_last, overflow, busy;
    logic [19:0] out_word;

    always #10 clk = ~clk; // 50 MHz

    hbuf_l1_buffer i_hbuf_l1_buffer (
        .clk(clk), .rst(rst), .hit_valid(hit_valid), .hit_word(hit_word),
        .bco_tick(bco_tick), .l1_accept(l1_accept), .out_valid(out_valid),
        .out_word(out_word), .out_last(out_last), .overflow(overflow), .busy(busy)
    );

    int n_tests = 0;
    int n_fail  = 0;
    int cur     = 0;
    int tnum    = 0;
    int ecnt [64];
    logic [19:0] edata [64][16];

    logic [19:0] cap_w [4096];
    logic        cap_l [4096];
    int          ncap  = 0;
    int          nlast = 0;
    int          pos   = 0;
    int          exp_last = 0;

    always @(negedge clk) begin
        if (!rst && out_valid && ncap < 4096) begin
            cap_w[ncap] = out_word;
            cap_l[ncap] = out_last;
            ncap++;
            if (out_last) nlast++;
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk) bco_tick = 1'b1;
        @(negedge clk) bco_tick = 1'b0;
        cur = (cur + 1) % 64;
        ecnt[cur] = 0;
    endtask

    task automatic hit(input logic [19:0] w);
        int b;
        @(negedge clk) begin hit_valid = 1'b1; hit_word = w; end
        @(negedge clk) hit_valid = 1'b0;
        b = int'(w[5:0]);
        if (ecnt[b] < 16) begin edata[b][ecnt[b]] = w; ecnt[b]++; end
    endtask

    task automatic wait_packets(input int target);
        while (nlast < target) @(negedge clk);
    endtask

    // compares one captured packet against the bench model
    task automatic check_packet(input int bucket, input int tn);
        int n;
        n = ecnt[bucket];
        check("R5 header", {12'd0, cap_w[pos]}, {12'd0, 4'hA, 10'(tn), 6'(bucket)});
        check("R7 header not last", {31'd0, cap_l[pos]}, 32'd0);
        for (int i = 0; i < n; i++)
            check("R6 data word", {12'd0, cap_w[pos + 1 + i]}, {12'd0, edata[bucket][i]});
        check(n == 0 ? "R8 empty trailer" : "R7 trailer",
              {12'd0, cap_w[pos + 1 + n]}, {12'd0, 4'hF, 16'(n)});
        check("R7 last on trailer", {31'd0, cap_l[pos + 1 + n]}, 32'd1);
        pos = pos + n + 2;
    endtask

    task automatic trig_one();
        @(negedge clk) l1_accept = 1'b1;
        @(negedge clk) l1_accept = 1'b0;
    endtask

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        int sel;
        int nh;
        for (int b = 0; b < 64; b++) ecnt[b] = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1 out_valid", {31'd0, out_valid}, 32'd0);
        check("R1 overflow", {31'd0, overflow}, 32'd0);
        check("R1 busy", {31'd0, busy}, 32'd0);

        // R2 R3 R4 R8 sweep: two laps over all buckets, hit count per lap differs
        for (int s = 0; s < 128; s++) begin
            tick();
            nh = (s + 2 * (s / 64)) % 5;
            for (int i = 0; i < nh; i++) hit({14'(s * 16 + i), 6'(cur)});
            sel = (cur - 42 + 64) % 64;
            trig_one();
            exp_last++;
            wait_packets(exp_last);
            check_packet(sel, tnum);
            tnum++;
        end

        // R9: bucket capacity and sticky overflow
        tick();
        for (int i = 0; i < 16; i++) hit({14'(1000 + i), 6'(cur)});
        check("R9 no overflow at 16", {31'd0, overflow}, 32'd0);
        hit({14'(2000), 6'(cur)});
        check("R9 overflow at 17", {31'd0, overflow}, 32'd1);
        sel = cur;
        for (int k = 0; k < 42; k++) tick();
        trig_one();
        exp_last++;
        wait_packets(exp_last);
        check("R9 bucket held 16", 32'(ecnt[sel]), 32'd16);
        check_packet(sel, tnum);
        tnum++;
        check("R9 overflow sticky", {31'd0, overflow}, 32'd1);

        // R10: six back-to-back triggers, five accepted, sixth dropped
        tick();
        for (int i = 0; i < 6; i++) hit({14'(3000 + i), 6'(cur)});
        sel = cur;
        for (int k = 0; k < 42; k++) tick();
        check("R10 busy before", {31'd0, busy}, 32'd0);
        @(negedge clk) l1_accept = 1'b1;
        repeat (6) @(negedge clk);
        l1_accept = 1'b0;
        exp_last += 5;
        wait_packets(exp_last);
        repeat (20) @(negedge clk);
        check("R10 packets served", 32'(nlast), 32'(exp_last));
        for (int k = 0; k < 5; k++) begin
            check_packet(sel, tnum);
            tnum++;
        end
        check("R10 busy set", {31'd0, busy}, 32'd1);
        check("R10 no extra words", 32'(ncap), 32'(pos));
        finish_run();
    end
endmodule